// File: doc/BRIEF.md
# Receive Byte Queue with Depth Event

This block buffers bytes that a serial receive engine delivers and hands them to a register-read path one at a time. It holds up to 16 bytes in arrival order. Software sees two count values in a "count minus one" encoding. The first is the occupancy readback. The second is a threshold that raises a level event for an interrupt block once enough bytes are waiting. A separate empty flag tells software whether the occupancy value is meaningful.

The write side is a valid/ready stream. `in_ready` is high whenever the queue has a free slot. The serial engine cannot stall, so a beat offered while `in_ready` is low is discarded and sets a sticky overflow flag. The read side is a plain pop strobe that stands for a read of the data register. `rd_data` always shows the oldest byte, or zero when the queue is empty. The pop takes effect at the clock edge.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `occ_m1`=0, `depth_evt`=0 and `overflow`=0.
- R2: Bytes leave the queue in the order they were accepted.
- R3: `in_ready` is high exactly when fewer than 16 bytes are held. A beat with `in_valid` and `in_ready` both high is stored at that clock edge.
- R4: With 16 bytes held, `full`=1. A beat offered while full is dropped and leaves the contents unchanged. That beat sets `overflow`, which stays set until reset.
- R5: When the queue holds N bytes (N from 1 to 16), `occ_m1` reads N-1 and `empty`=0. With no bytes held, `empty`=1 and `occ_m1` reads 0.
- R6: `depth_evt` is high exactly when the number of bytes held is at least `thr_m1`+1. The event is level-sensitive and follows the count in both directions.
- R7: With `thr_m1`=0, `depth_evt` rises as soon as one byte is held.
- R8: A push and a pop in the same cycle on a non-empty, non-full queue leave `occ_m1` unchanged. Both operations still take place.
- R9: While empty, `rd_data` reads 0. A pop while empty does not move the pointers, so the next byte pushed is the next byte read.
- R10: While not empty, `rd_data` shows the oldest byte. A pop removes that byte at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming byte is valid |
| in_ready | output | 1 | Queue can accept a byte |
| in_data | input | 8 | Incoming byte |
| rd_pop | input | 1 | Data-register read strobe; pops one byte |
| rd_data | output | 8 | Oldest byte, or 0 when empty |
| thr_m1 | input | 4 | Event threshold, desired count minus one |
| occ_m1 | output | 4 | Occupancy, count minus one (0 when empty) |
| empty | output | 1 | No bytes held |
| full | output | 1 | 16 bytes held |
| overflow | output | 1 | Sticky: a beat was dropped while full |
| depth_evt | output | 1 | Level event: count at least thr_m1+1 |

## Verification
Some properties are checked on every cycle. These are:
- a beat offered while full sets `overflow`, and `overflow` never clears without reset;
- `depth_evt` is present whenever a byte is held and the threshold is zero;
- `occ_m1` holds across a combined push and pop;
- an empty queue reads zero and stays empty under a lone pop;
- the two flags are never both set.

Other behaviours need a known history, so only the directed scenarios can show them. These are:
- byte ordering across a full fill and drain;
- the exact minus-one value of occupancy at each fill level;
- the event edge at a nonzero threshold in both directions;
- proof that an empty pop left the pointers in place.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned RXQ_DEPTH  = 16;
  localparam int unsigned RXQ_DATA_W = 8;
  typedef logic [RXQ_DATA_W-1:0] rxq_byte_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count
);
  logic [AW-1:0] wr_nxt, rd_nxt;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + AW'(1);
      assign rd_nxt = rd_ptr + AW'(1);
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count,
  input  logic [AW-1:0] thr_m1,
  output logic [AW-1:0] occ_m1,
  output logic          empty,
  output logic          full,
  output logic          evt
);
  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign occ_m1 = empty ? '0 : AW'(count - CW'(1));
  assign evt    = (count > CW'(thr_m1));
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH  = RXQ_DEPTH,
  parameter int unsigned DATA_W = RXQ_DATA_W,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  input  logic [AW-1:0]     thr_m1,
  output logic [AW-1:0]     occ_m1,
  output logic              empty,
  output logic              full,
  output logic              overflow,
  output logic              depth_evt
);
  logic          push, pop, ovf_q;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [DATA_W-1:0] head;

  assign in_ready = !full;
  assign push     = in_valid && !full;
  assign pop      = rd_pop && !empty;

  rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(push), .waddr(wr_ptr), .wdata(in_data),
    .raddr(rd_ptr), .rdata(head)
  );

  rxq_level #(.DEPTH(DEPTH)) u_level (
    .count(count), .thr_m1(thr_m1), .occ_m1(occ_m1),
    .empty(empty), .full(full), .evt(depth_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                  ovf_q <= 1'b0;
    else if (in_valid && full)   ovf_q <= 1'b1;
  end

  assign overflow = ovf_q;
  assign rd_data  = empty ? '0 : head;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int unsigned AW     = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              rd_pop,
  input logic [DATA_W-1:0] rd_data,
  input logic [AW-1:0]     thr_m1,
  input logic [AW-1:0]     occ_m1,
  input logic              empty,
  input logic              full,
  input logic              overflow,
  input logic              depth_evt
);
  // R4: a beat offered while full leaves a trace
  p_drop_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid) |=> overflow);
  // R4: overflow is sticky
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R3: an accepted beat makes the queue non-empty
  p_accept_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !rd_pop) |=> !empty);
  // R7: zero threshold fires on any byte
  p_thr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && thr_m1 == '0) |-> depth_evt);
  // R8: combined push and pop holds occupancy
  p_hold_occ_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && rd_pop && !empty) |=> ($stable(occ_m1) && !empty));
  // R9: empty reads zero
  p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (rd_data == '0));
  // R9: lone pop on empty stays empty
  p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_pop && !in_valid) |=> empty);
  // R5: flags exclusive
  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
endmodule

bind rx_byte_queue rxq_checker #(.AW(AW), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .rd_pop(rd_pop), .rd_data(rd_data), .thr_m1(thr_m1), .occ_m1(occ_m1),
  .empty(empty), .full(full), .overflow(overflow), .depth_evt(depth_evt)
);

// File: tb/sim_rx_byte_queue.sv
module sim_rx_byte_queue;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic [3:0] thr_m1 = 4'd15;
  logic [3:0] occ_m1;
  logic       empty, full, overflow, depth_evt;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_byte_queue u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .rd_pop(rd_pop), .rd_data(rd_data), .thr_m1(thr_m1),
    .occ_m1(occ_m1), .empty(empty), .full(full), .overflow(overflow),
    .depth_evt(depth_evt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; rd_pop = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    step();
    in_valid = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [7:0] exp);
    chk(req, rd_data, exp);
    rd_pop = 1'b1;
    step();
    rd_pop = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 occ", occ_m1, 0);
    chk("R1 evt", depth_evt, 0);
    chk("R1 ovf", overflow, 0);
  endtask

  task automatic t_order();
    push(8'hA1); push(8'hB2); push(8'hC3);
    chk("R5 occ three", occ_m1, 2);
    chk("R5 not empty", empty, 0);
    pop_expect("R10 head", 8'hA1);
    pop_expect("R2 second", 8'hB2);
    pop_expect("R2 third", 8'hC3);
    chk("R5 empty after drain", empty, 1);
    chk("R5 occ empty", occ_m1, 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 16; i++) begin
      chk("R3 ready", in_ready, 1);
      push(8'(i * 7 + 1));
    end
    chk("R4 full", full, 1);
    chk("R3 not ready", in_ready, 0);
    chk("R5 occ full", occ_m1, 15);
    chk("R4 no ovf yet", overflow, 0);
    push(8'hEE);
    chk("R4 ovf set", overflow, 1);
    chk("R4 occ kept", occ_m1, 15);
    for (int i = 0; i < 16; i++) pop_expect("R2 fill order", 8'(i * 7 + 1));
    chk("R4 dropped beat absent", empty, 1);
    chk("R4 ovf sticky", overflow, 1);
    do_reset();
    chk("R4 ovf cleared by reset", overflow, 0);
  endtask

  task automatic t_thresh();
    thr_m1 = 4'd3;
    push(8'h11); push(8'h12); push(8'h13);
    chk("R6 below thr", depth_evt, 0);
    push(8'h14);
    chk("R6 at thr", depth_evt, 1);
    push(8'h15);
    chk("R6 above thr", depth_evt, 1);
    pop_expect("R2 thr data", 8'h11);
    pop_expect("R2 thr data", 8'h12);
    chk("R6 falls below", depth_evt, 0);
    for (int i = 0; i < 3; i++) pop_expect("R2 thr drain", 8'(8'h13 + i));
    thr_m1 = 4'd0;
    #1;
    chk("R7 empty no evt", depth_evt, 0);
    push(8'h77);
    chk("R7 one byte evt", depth_evt, 1);
    pop_expect("R10 thr0 data", 8'h77);
    thr_m1 = 4'd15;
  endtask

  task automatic t_simul();
    push(8'h21); push(8'h22);
    chk("R8 occ before", occ_m1, 1);
    chk("R8 head before", rd_data, 8'h21);
    in_valid = 1'b1; in_data = 8'h23; rd_pop = 1'b1;
    step();
    in_valid = 1'b0; rd_pop = 1'b0;
    chk("R8 occ held", occ_m1, 1);
    pop_expect("R8 order a", 8'h22);
    pop_expect("R8 order b", 8'h23);
    chk("R8 drained", empty, 1);
  endtask

  task automatic t_empty_pop();
    chk("R9 empty reads 0", rd_data, 0);
    rd_pop = 1'b1;
    step(); step();
    rd_pop = 1'b0;
    chk("R9 still empty", empty, 1);
    chk("R9 occ still 0", occ_m1, 0);
    push(8'h55);
    chk("R9 pointers unmoved", rd_data, 8'h55);
    chk("R9 occ one", occ_m1, 0);
    pop_expect("R9 data", 8'h55);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_order();
    t_fill();
    t_thresh();
    t_simul();
    t_empty_pop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule